// File: doc/BRIEF.md
# Polled Character Port for Keyboard and Display

This block sits on a simple single-cycle register bus and lets a processor exchange characters with a keyboard and a display by polling. A keyboard strobe drops an 8-bit character code into an input holding register and raises an input-ready flag. The display takes its character from an output holding register. When the display can accept the next character, it pulses an acknowledge, and that raises an output-ready flag.

Software never writes the ready flags itself. They clear as a side effect of its buffer accesses. Reading the input holding register drops the input-ready flag. Writing the output holding register drops the output-ready flag. A processor loop therefore tests bit 3 of a status register, moves one byte, and repeats. If a second keystroke lands before the first one was read, a sticky lost-character bit records it.

The register map occupies four byte addresses:

| Address | Register | Read | Write |
|---|---|---|---|
| 0 | input holding register | character code (clears ready and lost bits) | ignored |
| 1 | input status | bit 3 ready, bit 4 lost character, other bits 0 | ignored |
| 2 | output holding register | reads 0 | loads character (clears ready) |
| 3 | output status | bit 3 ready, other bits 0 | ignored |

Top module: `char_io_port`

## Requirements
- R1: After reset, the input-ready flag is 0, the lost-character bit is 0, the output-ready flag is 1, and both holding registers are 0. Consequently `keyFull`=0, `dispPending`=0 and `dispData`=0.
- R2: A cycle with `keyStrobe`=1 loads `keyCode` into the input holding register (address 0) at the next clock edge and sets the input-ready flag. The flag reads as bit 3 of the input status register at address 1 and drives `keyFull`.
- R3: A bus read of address 0 returns the held character in the same cycle. At the next edge it clears the input-ready flag and the lost-character bit, unless a keystroke arrives in that same cycle, in which case that keystroke is loaded and the flag ends at 1.
- R4: A bus write to address 2 loads `busWdata` into the output holding register. The byte appears on `dispData` after the next edge. The same edge clears the output-ready flag (bit 3 of the output status register at address 3), which drives `dispPending`=1.
- R5: A `dispAck` pulse sets the output-ready flag at the next edge. If a write to address 2 happens in the same cycle, the write wins and the flag ends at 0.
- R6: Reading address 1 or address 3 changes neither ready flag nor the lost-character bit.
- R7: A keystroke that arrives while the input-ready flag is 1, and without a read of address 0 in the same cycle, still overwrites the held character. It also sets the lost-character bit, bit 4 of the input status register, and that bit stays set until a read of address 0.
- R8: Bus writes to addresses 0, 1 and 3 change no state. A read of address 2 returns 0 and changes no state. `busRdata` is 0 in every cycle without a bus read.
- R9: `busRdata` is combinational from the current address and register state. Flag and buffer changes caused by a bus access become visible only after the clock edge that ends that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access this cycle |
| busWr | input | 1 | 1 for write, 0 for read |
| busAddr | input | 2 | Register address 0..3 |
| busWdata | input | 8 | Write byte |
| busRdata | output | 8 | Read byte, valid in the access cycle |
| keyStrobe | input | 1 | Keyboard has a new character |
| keyCode | input | 8 | Keyboard character code |
| keyFull | output | 1 | Input-ready flag |
| dispAck | input | 1 | Display can take another character |
| dispData | output | 8 | Output holding register contents |
| dispPending | output | 1 | Inverse of the output-ready flag |

## Verification
Read data is due in the same cycle as the bus access. Every flag, lost-character and buffer effect of a strobe, acknowledge or access is due one edge later. The bench drives each stimulus half a period before an edge and compares `busRdata` one time unit after driving. It then lets the edge fire and compares the remaining outputs against a behavioural reference model that it advances at that same edge. Same-cycle collisions are driven as single steps so that the priority rules land on one known edge: read with keystroke, and write with acknowledge.

// File: rtl/kdp_pkg.sv
package kdp_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_IN_DATA  = 2'd0,
    SEL_IN_STAT  = 2'd1,
    SEL_OUT_DATA = 2'd2,
    SEL_OUT_STAT = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    rdEn;
    regSel_e rdSel;
    logic    ldIn;
    logic    rdIn;
    logic    ovrSet;
    logic    wrOut;
    logic    ack;
  } strobes_t;

endpackage

// File: rtl/kdp_ctrl.sv
module kdp_ctrl
  import kdp_pkg::*;
(
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              keyStrobe,
  input  logic              dispAck,
  input  logic              inFull,
  output strobes_t          strb
);

  logic rdCycle;
  logic wrCycle;

  assign rdCycle = busSel & ~busWr;
  assign wrCycle = busSel & busWr;

  always_comb begin
    strb        = '0;
    strb.rdEn   = rdCycle;
    strb.rdSel  = regSel_e'(busAddr);
    strb.ldIn   = keyStrobe;
    strb.rdIn   = rdCycle & (regSel_e'(busAddr) == SEL_IN_DATA);
    strb.wrOut  = wrCycle & (regSel_e'(busAddr) == SEL_OUT_DATA);
    strb.ack    = dispAck;
    strb.ovrSet = keyStrobe & inFull & ~strb.rdIn;
  end

endmodule

// File: rtl/kdp_datapath.sv
module kdp_datapath
  import kdp_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int READY_BIT = 3,
  parameter int OVR_BIT   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] keyCode,
  input  logic [DATA_W-1:0] busWdata,
  output logic              inFull,
  output logic              outReady,
  output logic [DATA_W-1:0] dispData,
  output logic [DATA_W-1:0] busRdata
);

  localparam logic [DATA_W-1:0] READY_MASK = DATA_W'(1) << READY_BIT;
  localparam logic [DATA_W-1:0] OVR_MASK   = DATA_W'(1) << OVR_BIT;

  logic [DATA_W-1:0] inBuf;
  logic [DATA_W-1:0] outBuf;
  logic              lostChar;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inBuf    <= '0;
      inFull   <= 1'b0;
      lostChar <= 1'b0;
    end else begin
      if (strb.ldIn) inBuf <= keyCode;
      if (strb.ldIn)      inFull <= 1'b1;
      else if (strb.rdIn) inFull <= 1'b0;
      if (strb.rdIn)        lostChar <= 1'b0;
      else if (strb.ovrSet) lostChar <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outBuf   <= '0;
      outReady <= 1'b1;
    end else begin
      if (strb.wrOut) begin
        outBuf   <= busWdata;
        outReady <= 1'b0;
      end else if (strb.ack) begin
        outReady <= 1'b1;
      end
    end
  end

  assign dispData = outBuf;

  always_comb begin
    busRdata = '0;
    if (strb.rdEn) begin
      unique case (strb.rdSel)
        SEL_IN_DATA:  busRdata = inBuf;
        SEL_IN_STAT:  busRdata = (inFull ? READY_MASK : '0) | (lostChar ? OVR_MASK : '0);
        SEL_OUT_DATA: busRdata = '0;
        SEL_OUT_STAT: busRdata = outReady ? READY_MASK : '0;
        default:      busRdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/char_io_port.sv
module char_io_port
  import kdp_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int READY_BIT = 3,
  parameter int OVR_BIT   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              keyStrobe,
  input  logic [DATA_W-1:0] keyCode,
  output logic              keyFull,
  input  logic              dispAck,
  output logic [DATA_W-1:0] dispData,
  output logic              dispPending
);

  strobes_t strb;
  logic     inFull;
  logic     outReady;

  kdp_ctrl u_ctrl (
    .busSel    (busSel),
    .busWr     (busWr),
    .busAddr   (busAddr),
    .keyStrobe (keyStrobe),
    .dispAck   (dispAck),
    .inFull    (inFull),
    .strb      (strb)
  );

  kdp_datapath #(
    .DATA_W    (DATA_W),
    .READY_BIT (READY_BIT),
    .OVR_BIT   (OVR_BIT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .keyCode  (keyCode),
    .busWdata (busWdata),
    .inFull   (inFull),
    .outReady (outReady),
    .dispData (dispData),
    .busRdata (busRdata)
  );

  assign keyFull     = inFull;
  assign dispPending = ~outReady;

endmodule

// File: rtl/char_io_port_chk.sv
module char_io_port_chk
  import kdp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              keyStrobe,
  input logic [DATA_W-1:0] keyCode,
  input logic              keyFull,
  input logic              dispAck,
  input logic [DATA_W-1:0] dispData,
  input logic              dispPending
);

  logic rdIn;
  logic wrOut;
  logic rdStat;
  logic wrOther;

  assign rdIn    = busSel & ~busWr & (busAddr == 2'd0);
  assign wrOut   = busSel & busWr & (busAddr == 2'd2);
  assign rdStat  = busSel & ~busWr & busAddr[0];
  assign wrOther = busSel & busWr & (busAddr != 2'd2);

  a_r2_key_sets_full: assert property (@(posedge clk) disable iff (!rstN)
    keyStrobe |=> keyFull);

  a_r3_read_clears_full: assert property (@(posedge clk) disable iff (!rstN)
    (rdIn && !keyStrobe) |=> !keyFull);

  a_r4_write_loads_output: assert property (@(posedge clk) disable iff (!rstN)
    wrOut |=> (dispPending && dispData == $past(busWdata)));

  a_r5_ack_sets_ready: assert property (@(posedge clk) disable iff (!rstN)
    (dispAck && !wrOut) |=> !dispPending);

  a_r6_status_read_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (rdStat && !keyStrobe && !dispAck) |=> ($stable(keyFull) && $stable(dispPending)));

  a_r8_stray_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (wrOther && !dispAck) |=> ($stable(dispData) && $stable(dispPending)));

endmodule

bind char_io_port char_io_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busSel      (busSel),
  .busWr       (busWr),
  .busAddr     (busAddr),
  .busWdata    (busWdata),
  .keyStrobe   (keyStrobe),
  .keyCode     (keyCode),
  .keyFull     (keyFull),
  .dispAck     (dispAck),
  .dispData    (dispData),
  .dispPending (dispPending)
);

// File: tb/char_io_port_tb.sv
module char_io_port_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0;
  logic       busWr = 1'b0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       keyStrobe = 1'b0;
  logic [7:0] keyCode = '0;
  logic       keyFull;
  logic       dispAck = 1'b0;
  logic [7:0] dispData;
  logic       dispPending;

  int checks = 0;
  int failures = 0;

  int mIn = 0, mInF = 0, mOvr = 0, mOut = 0, mOutF = 1;

  always #5 clk = ~clk;

  char_io_port u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .keyStrobe(keyStrobe), .keyCode(keyCode),
    .keyFull(keyFull), .dispAck(dispAck), .dispData(dispData), .dispPending(dispPending)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int modelRdata();
    if (!busSel || busWr) return 0;
    case (busAddr)
      2'd0: return mIn;
      2'd1: return (mInF << 3) | (mOvr << 4);
      2'd2: return 0;
      default: return mOutF << 3;
    endcase
  endfunction

  task automatic checkState(input string tag);
    chk(tag, "keyFull", int'(keyFull), mInF);
    chk(tag, "dispPending", int'(dispPending), 1 - mOutF);
    chk(tag, "dispData", int'(dispData), mOut);
  endtask

  // one cycle: drive at negedge, check read data, advance model at posedge, check state
  task automatic step(input string tag, input bit sel, input bit wr, input int addr,
                      input int wdata, input bit key, input int code, input bit ack);
    bit rdIn, wrOut;
    busSel = sel; busWr = wr; busAddr = 2'(addr); busWdata = 8'(wdata);
    keyStrobe = key; keyCode = 8'(code); dispAck = ack;
    #1;
    chk(tag, "busRdata", int'(busRdata), modelRdata());
    rdIn  = sel && !wr && addr == 0;
    wrOut = sel && wr && addr == 2;
    @(posedge clk);
    if (rdIn) mOvr = 0;
    else if (key && mInF == 1) mOvr = 1;
    if (key) begin mIn = code; mInF = 1; end
    else if (rdIn) mInF = 0;
    if (wrOut) begin mOut = wdata; mOutF = 0; end
    else if (ack) mOutF = 1;
    @(negedge clk);
    busSel = 0; keyStrobe = 0; dispAck = 0;
    checkState(tag);
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic rd(input string tag, input int a);
    step(tag, 1, 0, a, 0, 0, 0, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        @(negedge clk);
        // R1 reset state
        checkState("R1");
        rd("R1", 1); rd("R1", 3); rd("R1", 0);
        idle("R8");  // R8: no read gives zero
        // R2 keystroke
        step("R2", 0, 0, 0, 0, 1, 8'h41, 0);
        rd("R2", 1);
        rd("R6", 1); rd("R6", 3);  // R6 status reads have no side effect
        rd("R3", 0);               // R3 returns 0x41, clears flag
        rd("R3", 1);
        // R7 overrun
        step("R7", 0, 0, 0, 0, 1, 8'h42, 0);
        step("R7", 0, 0, 0, 0, 1, 8'h43, 0);
        rd("R7", 1);
        rd("R7", 1);
        rd("R7", 0);
        rd("R7", 1);
        // R3 read and keystroke in the same cycle
        step("R3", 0, 0, 0, 0, 1, 8'h10, 0);
        step("R3", 1, 0, 0, 0, 1, 8'h11, 0);
        rd("R3", 1);
        rd("R3", 0);
        // R4 output write
        step("R4", 1, 1, 2, 8'h5A, 0, 0, 0);
        rd("R4", 3);
        // R8 ignored accesses
        step("R8", 1, 1, 0, 8'hFF, 0, 0, 0);
        step("R8", 1, 1, 1, 8'hFF, 0, 0, 0);
        step("R8", 1, 1, 3, 8'hFF, 0, 0, 0);
        rd("R8", 2);
        rd("R8", 0); rd("R8", 1);
        // R5 acknowledge
        step("R5", 0, 0, 0, 0, 0, 0, 1);
        rd("R5", 3);
        step("R5", 1, 1, 2, 8'hA5, 0, 0, 1);
        rd("R5", 3);
        // R9 mixed traffic pattern
        for (int i = 0; i < 24; i++) begin
          step("R9", 0, 0, 0, 0, 1, (i * 37 + 5) & 255, i % 3 == 0);
          if (i % 4 != 1) rd("R9", 0);
          rd("R9", 1);
          step("R9", 1, 1, 2, (i * 91) & 255, 0, 0, i % 5 == 0);
          rd("R9", 3);
        end
      end
      begin
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule